// File: doc/BRIEF.md
# Multiblock CRC-12 Parity Generator

This block computes a 12-bit cyclic redundancy check over the scrambled payload of a 64b/66b link. Each multiblock is 32 blocks of 64 payload bits, which gives 2048 bits per parity word. The 2-bit sync headers are not part of the input. One payload block arrives per cycle in which `blk_valid` is high. The whole 64-bit word goes into the shift register in that cycle, through a combinational network that does the same work as 64 serial steps. Bits enter most-significant first.

A block counter groups the incoming blocks into multiblocks. A start marker on a block forces that block to be the first of a new multiblock, and any partial result is thrown away. When the 32nd block has been taken in, the finished parity word is registered and flagged with a one-cycle strobe. In the same cycle the accumulator is cleared so that the next multiblock starts from zero. The parity word stays on its output until the next strobe.

Top module: `mbcrc12_gen`

## Requirements
- R1: The parity word equals the remainder of a bit-serial division of the 2048 payload bits, taken MSB-first within each 64-bit word and in block order. The generator is x^12+x^9+x^8+x^3+x^2+x+1: feedback taps 12'h30F, written 0x987 in the implicit-plus-one notation. The shift register starts from zero.
- R2: `par_valid` is high for exactly one cycle. That is the cycle after the clock edge that accepts the 32nd block of a multiblock, and it is low in every other cycle.
- R3: The accumulator restarts from zero after every multiblock. Back-to-back multiblocks with no idle cycle between them each produce their own independent parity.
- R4: Cycles with `blk_valid` low change neither the block count nor the accumulator, whatever `blk_data` and `blk_som` carry.
- R5: A valid block with `blk_som` high becomes block 1 of a new multiblock. The partial result of an unfinished multiblock is discarded, and the strobe comes 32 valid blocks after the marked block.
- R6: `par_word` holds the value from the most recent strobe until the next strobe.
- R7: Synchronous active-high `rst` forces `par_valid` to 0 and `par_word` to 0. The first valid block after reset is block 1.
- R8: When no marker arrives, counting runs freely from reset, and every 32 consecutive valid blocks form one multiblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | Payload block present this cycle |
| blk_som | input | 1 | Marks the block as the first of a multiblock |
| blk_data | input | 64 | Scrambled 64-bit block payload |
| par_valid | output | 1 | One-cycle strobe for a finished parity word |
| par_word | output | 12 | Parity of the last finished multiblock |

## Verification
Two functions can fall in the same cycle. The first is completing a multiblock, which captures the parity and clears the accumulator. The second is starting the next multiblock, which seeds the update from zero. The bench provokes this by sending multiblocks back to back with no idle cycle, and by placing a start marker on the block that directly follows a 32nd block. A bit-serial model in the bench computes the parity, and it is compared with `par_word` and with the timing of the strobe. The bench also checks a start marker that arrives partway through a multiblock. There the strobe must not appear at the old 32-block position and must appear 32 blocks after the marker.

// File: rtl/mbcrc_pkg.sv
package mbcrc_pkg;
    localparam int          CRC_W    = 12;
    localparam int          DATA_W   = 64;
    localparam int          MB_BLKS  = 32;
    // x^12+x^9+x^8+x^3+x^2+x+1, leading term implicit
    localparam logic [11:0] CRC_TAPS = 12'h30F;

    typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/mbcrc_lfsr_step.sv
module mbcrc_lfsr_step #(
    parameter int                 CRC_W     = 12,
    parameter int                 DATA_W    = 64,
    parameter logic [CRC_W-1:0]   TAPS      = 12'h30F,
    parameter bit                 MSB_FIRST = 1'b1
) (
    input  logic [CRC_W-1:0]  seed,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  result
);
    // ordered[DATA_W-1] is the first bit shifted in
    logic [DATA_W-1:0] ordered;

    generate
        if (MSB_FIRST) begin : g_msb
            assign ordered = din;
        end else begin : g_lsb
            for (genvar i = 0; i < DATA_W; i++) begin : g_rev
                assign ordered[i] = din[DATA_W-1-i];
            end
        end
    endgenerate

    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = seed;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ ordered[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ TAPS;
            end
        end
        result = acc;
    end
endmodule

// File: rtl/mbcrc_blk_ctr.sv
module mbcrc_blk_ctr #(
    parameter int BLKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic restart,
    output logic is_first,
    output logic is_last
);
    localparam int                CNT_W    = (BLKS > 1) ? $clog2(BLKS) : 1;
    localparam logic [CNT_W-1:0]  LAST_IDX = CNT_W'(BLKS - 1);
    localparam logic [CNT_W-1:0]  AFTER_SOM = (BLKS > 1) ? CNT_W'(1) : '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t          st_d, st_q;
    logic [CNT_W-1:0] idx;

    always_comb begin
        st_d     = st_q;
        idx      = restart ? '0 : st_q.cnt;
        is_first = (idx == '0);
        is_last  = (idx == LAST_IDX);
        if (adv) begin
            st_d.cnt = is_last ? '0 : idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST_IDX);                                       // R8
    AST_IDLE_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(st_q.cnt));                                 // R4
    AST_SOM_RESTART: assert property (@(posedge clk) disable iff (rst)
        (adv && restart) |=> (st_q.cnt == AFTER_SOM));               // R5
endmodule

// File: rtl/mbcrc12_gen.sv
module mbcrc12_gen
    import mbcrc_pkg::*;
#(
    parameter int                 DATA_W = mbcrc_pkg::DATA_W,
    parameter int                 BLKS   = mbcrc_pkg::MB_BLKS,
    parameter logic [CRC_W-1:0]   TAPS   = mbcrc_pkg::CRC_TAPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_valid,
    input  logic              blk_som,
    input  logic [DATA_W-1:0] blk_data,
    output logic              par_valid,
    output logic [CRC_W-1:0]  par_word
);
    typedef struct packed {
        crc_t acc;
        crc_t par;
        logic strobe;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    first_blk, last_blk;
    crc_t    seed, step_res;

    mbcrc_blk_ctr #(
        .BLKS (BLKS)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .adv      (blk_valid),
        .restart  (blk_som),
        .is_first (first_blk),
        .is_last  (last_blk)
    );

    // a first block always seeds from zero, dropping any partial result
    assign seed = first_blk ? '0 : st_q.acc;

    mbcrc_lfsr_step #(
        .CRC_W     (CRC_W),
        .DATA_W    (DATA_W),
        .TAPS      (TAPS),
        .MSB_FIRST (1'b1)
    ) u_step (
        .seed   (seed),
        .din    (blk_data),
        .result (step_res)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (blk_valid) begin
            if (last_blk) begin
                st_d.par    = step_res;
                st_d.strobe = 1'b1;
                st_d.acc    = '0;
            end else begin
                st_d.acc    = step_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_valid = st_q.strobe;
    assign par_word  = st_q.par;

    AST_STROBE_AFTER_BLOCK: assert property (@(posedge clk) disable iff (rst)
        st_q.strobe |-> $past(blk_valid));                           // R2
    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        st_q.strobe |-> (st_q.acc == '0));                           // R3
    AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !blk_valid |=> ($stable(st_q.acc) && !st_q.strobe));         // R4
    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_q.strobe |-> $stable(st_q.par));                         // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!st_q.strobe && st_q.par == '0));            // R7
endmodule

// File: tb/mbcrc12_gen_tb.sv
module mbcrc12_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_valid = 1'b0;
    logic        blk_som = 1'b0;
    logic [63:0] blk_data = '0;
    logic        par_valid;
    logic [11:0] par_word;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // bench model state
    int          m_cnt = 0;
    logic [11:0] m_crc = '0;
    logic        e_pv  = 1'b0;
    logic [11:0] e_par = '0;

    always #10 clk = ~clk;

    mbcrc12_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .blk_valid (blk_valid),
        .blk_som   (blk_som),
        .blk_data  (blk_data),
        .par_valid (par_valid),
        .par_word  (par_word)
    );

    // bit-serial division, MSB first, taps 0x30F
    function automatic logic [11:0] ser(input logic [11:0] c, input logic [63:0] d);
        logic [11:0] r;
        logic        fb;
        r = c;
        for (int i = 63; i >= 0; i--) begin
            fb = r[11] ^ d[i];
            r  = {r[10:0], 1'b0};
            if (fb) r = r ^ 12'h30F;
        end
        return r;
    endfunction

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic som, input logic [63:0] d, input string tag);
        int idx;
        logic [11:0] s;
        blk_valid = v;
        blk_som   = som;
        blk_data  = d;
        @(posedge clk);
        #1;
        e_pv = 1'b0;
        if (v) begin
            idx = som ? 0 : m_cnt;
            s   = (idx == 0) ? 12'h000 : m_crc;
            s   = ser(s, d);
            if (idx == 31) begin
                e_pv  = 1'b1;
                e_par = s;
                m_crc = '0;
                m_cnt = 0;
            end else begin
                m_crc = s;
                m_cnt = idx + 1;
            end
        end
        chk({11'd0, par_valid}, {11'd0, e_pv}, {tag, " R2 strobe"});
        chk(par_word, e_par, e_pv ? {tag, " R1 parity"} : {tag, " R6 hold"});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        blk_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_cnt = 0; m_crc = '0; e_pv = 1'b0; e_par = '0;
        chk({11'd0, par_valid}, 12'd0, "R7 reset strobe");
        chk(par_word, 12'd0, "R7 reset word");
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (4) @(posedge clk);
        #1;
        do_reset();

        // R8: no markers at all, first block after reset is block 1
        for (int b = 0; b < 32; b++) step(1'b1, 1'b0, {$urandom, $urandom}, "R8 free");

        // R1: all zero payload gives zero parity
        for (int b = 0; b < 32; b++) step(1'b1, b == 0, 64'd0, "R1 zeros");
        chk(par_word, 12'h000, "R1 zero multiblock");

        // R1: single one in the final bit leaves exactly the taps; back to back (R3)
        for (int b = 0; b < 32; b++) step(1'b1, b == 0, (b == 31) ? 64'd1 : 64'd0, "R3 b2b");
        chk(par_word, 12'h30F, "R1 last-bit one");

        // R6: word holds across idle cycles with noisy inputs (R4)
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, {$urandom, $urandom}, "R4 idle");
        chk(par_word, 12'h30F, "R6 held word");

        // R5: early marker after 10 blocks, partial dropped
        for (int b = 0; b < 10; b++) step(1'b1, b == 0, {$urandom, $urandom}, "R5 partial");
        for (int b = 0; b < 32; b++) step(1'b1, b == 0, {$urandom, $urandom}, "R5 restart");

        // R3: marker on block straight after a 32nd block
        for (int b = 0; b < 32; b++) step(1'b1, b == 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3 ones");

        // R4: gaps inside a multiblock
        for (int b = 0; b < 32; b++) begin
            step(1'b1, b == 0, {$urandom, $urandom}, "R4 gap");
            if ((b % 3) == 1) step(1'b0, 1'b0, {$urandom, $urandom}, "R4 gap idle");
        end

        // R7: reset partway through, then free count again
        for (int b = 0; b < 13; b++) step(1'b1, 1'b0, {$urandom, $urandom}, "R7 pre");
        do_reset();
        for (int b = 0; b < 32; b++) step(1'b1, 1'b0, {$urandom, $urandom}, "R7 post");

        // random mix: valid 3/4, rare markers
        for (int k = 0; k < 1200; k++) begin
            step(($urandom % 4) != 0, ($urandom % 50) == 0, {$urandom, $urandom}, "R1 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule